// File: doc/BRIEF.md
# DRAM Refresh Scheduler and Strobe Sequencer

This block keeps every row of a 512-row asynchronous DRAM inside its retention window. A free-running interval timer marks one refresh as owed each time it expires, and a saturating tally holds up to eight owed refreshes. While anything is owed the block raises a request to the memory access controller. When the controller answers with a grant, the block takes the RAS, CAS, WE and address lines and runs complete refresh cycles back to back until nothing is owed or the grant is withdrawn at a cycle boundary.

Two refresh methods are available, and the method is chosen per cycle through a mode input. In CAS-before-RAS mode, CAS falls one setup period ahead of RAS, stays low for the whole RAS-low window and rises together with RAS; the DRAM supplies the row itself. In RAS-only mode, CAS stays high, and the block drives the row from its own 9-bit counter, which steps after every RAS-only cycle. A one-clock done pulse marks the end of each cycle's precharge. With the default timing parameters at 100 MHz, a cycle lasts 60 ns of strobe activity plus one idle clock, so the 45 ns cycle time, 25 ns RAS-low time and 15 ns RAS-high time are all met.

Top module: `dram_refresh_engine`

## Requirements
- R1: After a synchronous active-low reset, req_o and done_o are 0, drive_o is 0, ras_n_o, cas_n_o and we_n_o are 1 and addr_o is 0.
- R2: The interval timer marks one refresh as owed every INTERVAL_CYC clocks, counted from the end of reset, and req_o is 1 exactly while at least one refresh is owed.
- R3: At most MAX_OWED (default 8) refreshes are held as owed; a timer expiry that finds the tally full is dropped, and an expiry in the same clock as a cycle start leaves the tally unchanged.
- R4: A refresh cycle starts only from idle, in a clock where grant_i is 1 and a refresh is owed; each start removes one owed refresh, and the mode input is sampled at that start and held for the whole cycle.
- R5: In CAS-before-RAS mode (mode input 1), cas_n_o is 0 for the SETUP_CYC clocks before ras_n_o falls, stays 0 while ras_n_o is 0, and returns to 1 in the same clock as ras_n_o; addr_o is 0.
- R6: In RAS-only mode (mode input 0), cas_n_o stays 1 for the whole cycle and addr_o carries the row counter value from setup through precharge.
- R7: The 9-bit row counter advances by one at the end of each RAS-only cycle, wraps from 511 to 0, and is left unchanged by CAS-before-RAS cycles.
- R8: Each cycle holds ras_n_o high for SETUP_CYC clocks, low for RAS_LOW_CYC clocks, then high for PRE_CYC precharge clocks.
- R9: we_n_o is 1 in every clock.
- R10: done_o is 1 for exactly the one clock after the last precharge clock; if grant_i is still 1 and a refresh is owed in that clock, the next cycle begins at the following clock.
- R11: drive_o is 1 exactly during setup, RAS-low and precharge; outside a cycle the strobes are 1 and addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grant_i | input | 1 | Bus grant from the access controller |
| cbr_mode_i | input | 1 | 1 selects CAS-before-RAS, 0 selects RAS-only |
| req_o | output | 1 | Refresh request, high while refreshes are owed |
| done_o | output | 1 | One-clock pulse after each cycle's precharge |
| drive_o | output | 1 | High while the block owns the DRAM strobes |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, held inactive |
| addr_o | output | 9 | Row address for RAS-only cycles |

## Verification
The assertions take for granted that grant_i, once it has started a cycle, is not needed again until the cycle ends, since the sequencer ignores it mid-cycle, and that the mode input only matters in the start clock. The stimulus therefore withdraws the grant and flips the mode at arbitrary clocks, including mid-cycle, so that the latching at the start is exercised. A short interval is used so that the owed tally saturates while the grant is low and the row counter wraps within one long RAS-only run.

// File: rtl/rfsh_pkg.sv
// Shared types for the DRAM refresh engine.
// Assumes: none beyond the enum encoding being internal only.
package rfsh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_PRECH  = 2'd3
    } rfsh_state_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
// Free-running interval timer. Pulses tick_o for one clock every
// INTERVAL_CYC clocks, the first pulse INTERVAL_CYC clocks after reset.
// Assumes: INTERVAL_CYC >= 2.
module rfsh_interval_timer #(
    parameter int INTERVAL_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = $clog2(INTERVAL_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL_CYC - 1);

    logic [CNT_W-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    // Count clocks and restart on each expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else cnt_q <= cnt_q + 1'b1;
    end

    // Two expiries never sit in adjacent clocks.
    p_tick_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/rfsh_owed_tally.sv
// Saturating tally of refreshes owed. Expiries add one, cycle starts
// remove one; an expiry that finds the tally full is dropped.
// Assumes: start_i is only raised while owed_nz_o is 1.
module rfsh_owed_tally #(
    parameter int MAX_OWED = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic start_i,
    output logic owed_nz_o
);
    localparam int OWED_W = $clog2(MAX_OWED + 1);
    localparam logic [OWED_W-1:0] CAP = OWED_W'(MAX_OWED);

    logic [OWED_W-1:0] owed_q;

    assign owed_nz_o = (owed_q != '0);

    // Add on expiry, remove on start, cancel when both arrive together.
    always_ff @(posedge clk) begin
        if (!rst_n) owed_q <= '0;
        else if (tick_i && !start_i && owed_q != CAP) owed_q <= owed_q + 1'b1;
        else if (start_i && !tick_i) owed_q <= owed_q - 1'b1;
    end

    p_owed_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        owed_q <= CAP);
    p_start_needs_owed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> owed_q != '0);
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (owed_q == CAP && tick_i && !start_i) |=> owed_q == CAP);
endmodule

// File: rtl/rfsh_row_counter.sv
// Row counter for RAS-only refresh. Steps by one on advance_i and
// wraps naturally at the top of its width.
// Assumes: advance_i is a single-clock pulse per RAS-only cycle.
module rfsh_row_counter #(
    parameter int ROW_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance_i,
    output logic [ROW_W-1:0] row_o
);
    logic [ROW_W-1:0] row_q;

    assign row_o = row_q;

    // Advance once per finished RAS-only cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) row_q <= '0;
        else if (advance_i) row_q <= row_q + 1'b1;
    end

    p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        advance_i |=> row_q == $past(row_q) + 1'b1);
    p_row_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !advance_i |=> $stable(row_q));
endmodule

// File: rtl/rfsh_sequencer.sv
// Refresh strobe sequencer. From idle, starts a cycle when granted and
// a refresh is owed, then walks setup, RAS-low and precharge phases.
// Mode is latched at the start. Strobes decode from registered state.
// Assumes: every phase length parameter is at least 1.
module rfsh_sequencer
    import rfsh_pkg::*;
#(
    parameter int ROW_W       = 9,
    parameter int SETUP_CYC   = 1,
    parameter int RAS_LOW_CYC = 3,
    parameter int PRE_CYC     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_i,
    input  logic             cbr_mode_i,
    input  logic             owed_nz_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             start_o,
    output logic             row_adv_o,
    output logic             done_o,
    output logic             drive_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic [ROW_W-1:0] addr_o
);
    localparam int MAX_A  = (SETUP_CYC > RAS_LOW_CYC) ? SETUP_CYC : RAS_LOW_CYC;
    localparam int MAX_PH = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
    localparam int PH_W   = (MAX_PH > 1) ? $clog2(MAX_PH) : 1;
    localparam logic [PH_W-1:0] SETUP_LAST = PH_W'(SETUP_CYC - 1);
    localparam logic [PH_W-1:0] LOW_LAST   = PH_W'(RAS_LOW_CYC - 1);
    localparam logic [PH_W-1:0] PRE_LAST   = PH_W'(PRE_CYC - 1);

    rfsh_state_e      state_q, state_d;
    logic [PH_W-1:0]  ph_q, ph_d;
    logic             cbr_q;
    logic             done_q;
    logic             last_prech;

    assign start_o    = (state_q == ST_IDLE) && grant_i && owed_nz_i;
    assign last_prech = (state_q == ST_PRECH) && (ph_q == PRE_LAST);
    assign row_adv_o  = last_prech && !cbr_q;
    assign done_o     = done_q;

    // Next phase and phase position.
    always_comb begin
        state_d = state_q;
        ph_d    = ph_q + 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                ph_d = '0;
                if (start_o) state_d = ST_SETUP;
            end
            ST_SETUP: if (ph_q == SETUP_LAST) begin
                state_d = ST_ACTIVE;
                ph_d    = '0;
            end
            ST_ACTIVE: if (ph_q == LOW_LAST) begin
                state_d = ST_PRECH;
                ph_d    = '0;
            end
            ST_PRECH: if (ph_q == PRE_LAST) begin
                state_d = ST_IDLE;
                ph_d    = '0;
            end
            default: begin
                state_d = ST_IDLE;
                ph_d    = '0;
            end
        endcase
    end

    // Phase registers, latched mode and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ph_q    <= '0;
            cbr_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            ph_q    <= ph_d;
            done_q  <= last_prech;
            if (start_o) cbr_q <= cbr_mode_i;
        end
    end

    // Strobe and address decode from the registered phase.
    always_comb begin
        drive_o = (state_q != ST_IDLE);
        ras_n_o = (state_q != ST_ACTIVE);
        cas_n_o = !(cbr_q && (state_q == ST_SETUP || state_q == ST_ACTIVE));
        addr_o  = (drive_o && !cbr_q) ? row_i : '0;
    end

    // Checker state: length of the current RAS-low run.
    logic [PH_W:0] low_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) low_run_q <= '0;
        else if (!ras_n_o) low_run_q <= low_run_q + 1'b1;
        else low_run_q <= '0;
    end

    p_cbr_cas_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n_o) && cbr_q) |-> $past(!cas_n_o));
    p_cbr_cas_with_ras_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n_o && cbr_q) |-> !cas_n_o);
    p_rasonly_cas_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && !cbr_q) |-> cas_n_o);
    p_ras_low_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n_o) |-> low_run_q == (PH_W+1)'(RAS_LOW_CYC));
    p_no_grant_no_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !grant_i) |=> !drive_o);
    p_mode_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drive_o && $past(drive_o)) |-> $stable(cbr_q));
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_after_prech_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !drive_o && $past(drive_o) && $past(ras_n_o));
endmodule

// File: rtl/dram_refresh_engine.sv
// DRAM refresh engine top. Joins the interval timer, the owed tally,
// the row counter and the strobe sequencer. WE is tied inactive.
// Assumes: default phase lengths are for a 100 MHz clock.
module dram_refresh_engine #(
    parameter int INTERVAL_CYC = 1562,
    parameter int MAX_OWED     = 8,
    parameter int ROW_W        = 9,
    parameter int SETUP_CYC    = 1,
    parameter int RAS_LOW_CYC  = 3,
    parameter int PRE_CYC      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant_i,
    input  logic             cbr_mode_i,
    output logic             req_o,
    output logic             done_o,
    output logic             drive_o,
    output logic             ras_n_o,
    output logic             cas_n_o,
    output logic             we_n_o,
    output logic [ROW_W-1:0] addr_o
);
    logic             tick;
    logic             start;
    logic             owed_nz;
    logic             row_adv;
    logic [ROW_W-1:0] row;

    rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    rfsh_owed_tally #(.MAX_OWED(MAX_OWED)) u_tally (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .start_i   (start),
        .owed_nz_o (owed_nz)
    );

    rfsh_row_counter #(.ROW_W(ROW_W)) u_rows (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (row_adv),
        .row_o     (row)
    );

    rfsh_sequencer #(
        .ROW_W       (ROW_W),
        .SETUP_CYC   (SETUP_CYC),
        .RAS_LOW_CYC (RAS_LOW_CYC),
        .PRE_CYC     (PRE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .grant_i    (grant_i),
        .cbr_mode_i (cbr_mode_i),
        .owed_nz_i  (owed_nz),
        .row_i      (row),
        .start_o    (start),
        .row_adv_o  (row_adv),
        .done_o     (done_o),
        .drive_o    (drive_o),
        .ras_n_o    (ras_n_o),
        .cas_n_o    (cas_n_o),
        .addr_o     (addr_o)
    );

    assign req_o  = owed_nz;
    assign we_n_o = 1'b1;

    p_req_tracks_owed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !tick) |=> !req_o);
    p_drive_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(drive_o)) |-> $past(req_o) && $past(grant_i));
endmodule

// File: tb/tb_dram_refresh_engine.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with every output on each falling edge.
module tb_dram_refresh_engine;
    localparam int IV  = 10;
    localparam int CAP = 8;
    localparam int S   = 1;
    localparam int L   = 3;
    localparam int P   = 2;
    localparam int TOT = S + L + P;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       grant = 1'b0;
    logic       mode = 1'b1;
    logic       req, done, drive, ras_n, cas_n, we_n;
    logic [8:0] addr;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Model state.
    int m_t = 0, m_owed = 0, m_ph = 0, m_row = 0;
    bit m_cbr = 0, m_done = 0;

    // Wrap observation.
    int  last_row = -1;
    bit  saw_wrap = 0;
    logic prev_ras = 1'b1;

    always #5 clk = ~clk;

    dram_refresh_engine #(.INTERVAL_CYC(IV), .MAX_OWED(CAP)) dut (
        .clk(clk), .rst_n(rst_n), .grant_i(grant), .cbr_mode_i(mode),
        .req_o(req), .done_o(done), .drive_o(drive), .ras_n_o(ras_n),
        .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        bit tick, start;
        if (!rst_n) begin
            m_t = 0; m_owed = 0; m_ph = 0; m_row = 0; m_cbr = 0; m_done = 0;
        end else begin
            tick  = (m_t == IV - 1);
            m_t   = tick ? 0 : m_t + 1;
            start = (m_ph == 0) && grant && (m_owed > 0);
            if (tick && !start && m_owed < CAP) m_owed++;
            else if (start && !tick) m_owed--;
            m_done = 0;
            if (m_ph == 0) begin
                if (start) begin m_ph = 1; m_cbr = mode; end
            end else if (m_ph == TOT) begin
                m_ph = 0; m_done = 1;
                if (!m_cbr) m_row = (m_row + 1) % 512;
            end else m_ph++;
        end
    end

    // Compare on the falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            bit act_ph, setup_or_low;
            act_ph       = (m_ph >= S + 1) && (m_ph <= S + L);
            setup_or_low = (m_ph >= 1) && (m_ph <= S + L);
            chk("R2/R3 req", req, m_owed > 0);
            chk("R10 done", done, m_done);
            chk("R4/R11 drive", drive, m_ph != 0);
            chk("R8 ras_n", ras_n, !act_ph);
            chk(m_cbr ? "R5 cas_n" : "R6 cas_n", cas_n, !(m_cbr && setup_or_low));
            chk("R9 we_n", we_n, 1);
            chk("R6/R11 addr", addr, (m_ph != 0 && !m_cbr) ? m_row : 0);
            if (prev_ras && !ras_n && drive && cas_n) begin
                if (last_row == 511 && addr == 0) saw_wrap = 1;
                last_row = addr;
            end
            prev_ras = ras_n;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        cyc(4);
        @(negedge clk) rst_n = 1'b1;
        #1;
        // R1: reset values at the ports.
        chk("R1 req", req, 0);
        chk("R1 done", done, 0);
        chk("R1 drive", drive, 0);
        chk("R1 ras_n", ras_n, 1);
        chk("R1 cas_n", cas_n, 1);
        chk("R1 addr", addr, 0);
        // R3: let the tally fill while the grant stays low.
        cyc(130);
        #1 chk("R3 req held while saturated", req, 1);
        // CAS-before-RAS drain.
        grant = 1'b1;
        cyc(100);
        // R4: mode flips mid-cycle.
        for (int i = 0; i < 20; i++) begin
            mode = ~mode;
            cyc(3);
        end
        grant = 1'b0;
        cyc(20);
        // R7: long RAS-only run to wrap the row counter.
        mode  = 1'b0;
        grant = 1'b1;
        cyc(5400);
        chk("R7 row wrap 511 to 0 seen", saw_wrap, 1);
        // R4: short grant pulses.
        for (int i = 0; i < 30; i++) begin
            grant = (i % 3 == 0);
            mode  = (i % 2 == 0);
            cyc(1);
        end
        grant = 1'b0;
        cyc(30);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        #(20000 * 10);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule